// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds recently used virtual-to-physical page translations. Every entry is compared with the incoming request at once. An entry carries the virtual page number, the owning address-space identifier, the physical frame number, a two-bit permission code and a pin flag. A request names a page, an address space and an access kind. One clock later the block reports one of three results: a hit with the frame, a miss, or a permission fault. Entries are tagged by address space, so a context switch needs no flush. Translations from different spaces for the same page live side by side.

When a lookup misses, the page-table walker outside the block fetches the translation and presents it on the refill port. If an entry with the same page and identifier already exists, the refill rewrites it in place. Otherwise a round-robin pointer picks a victim, skipping pinned entries. If every entry is pinned, the refill is discarded and a one-cycle drop flag is raised. A flush command clears every unpinned entry, or only the unpinned entries of one address space, as a mode input selects.

Top module: `asid_tlb`

## Requirements
- R1: A lookup of a valid entry returns, on the cycle after the request, `rsp_pfn` and `rsp_perm` of that entry. `rsp_hit` is set when access is allowed.
- R2: A hit needs both the page number and the address-space identifier to match. The same page under another identifier reports a miss, with `rsp_pfn` and `rsp_perm` zero.
- R3: After a refill, a later lookup of that page and identifier hits.
- R4: Permission codes are 0 read-only, 1 read-write, 2 execute-only and 3 no access. Access kinds are 0 read, 1 write, 2 execute and 3 treated as read. A write faults unless the code is 1. A read faults on codes 2 and 3. An execute faults only on code 3. On a fault `rsp_fault` is set and the frame and code are still reported.
- R5: A refill with no matching entry goes to the first unpinned entry found at or after the round-robin pointer, searching circularly. The pointer then moves to the entry after the victim.
- R6: If no entry matches and every entry is valid and pinned, the refill changes nothing and `rf_drop` is high for exactly the following cycle.
- R7: A valid pinned entry is never chosen as a victim and is never cleared by a flush.
- R8: A flush with `fl_by_asid`=0 invalidates every unpinned entry.
- R9: A flush with `fl_by_asid`=1 invalidates only unpinned entries whose identifier equals `fl_asid`.
- R10: A refill whose page and identifier match a valid entry rewrites that entry's frame, permission and pin flag, and leaves the pointer unchanged.
- R11: `rsp_valid` is high exactly on the cycle after `lk_valid`. While it is high, exactly one of hit, miss and fault is set. After reset all outputs are zero and the table is empty.
- R12: A lookup sees the table as it was before any refill or flush in the same cycle. A refill in the same cycle as a flush is written after the flush, so it survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address space of the request |
| lk_kind | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation found, access allowed |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Translation found, access denied |
| rsp_pfn | output | PFN_W | Physical frame number |
| rsp_perm | output | 2 | Permission code of the matched entry |
| rf_valid | input | 1 | Refill write |
| rf_vpn | input | VPN_W | Refill page number |
| rf_asid | input | ASID_W | Refill address space |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_perm | input | 2 | Refill permission code |
| rf_wired | input | 1 | Pin the refilled entry |
| rf_drop | output | 1 | Previous-cycle refill was discarded |
| fl_valid | input | 1 | Flush command |
| fl_by_asid | input | 1 | 1: flush only `fl_asid`; 0: flush all unpinned |
| fl_asid | input | ASID_W | Identifier for a selective flush |

## Verification
A lookup, a refill and a flush can all fall in the same clock. The bench drives a refill of the very page being looked up in one cycle and expects a miss, then a hit on the next request. It also drives a refill together with a flush of all unpinned entries and expects the new entry to survive. A behavioural model applies the same-cycle order stated in R12 and is compared with the outputs on every clock.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      PERM_RO   = 2'd0,
      PERM_RW   = 2'd1,
      PERM_XO   = 2'd2,
      PERM_NONE = 2'd3
   } perm_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_ALT   = 2'd3
   } acc_e;

   function automatic logic access_denied(perm_e p, acc_e a);
      logic deny;
      case (a)
         ACC_WRITE: deny = (p != PERM_RW);
         ACC_EXEC:  deny = (p == PERM_NONE);
         default:   deny = (p == PERM_XO) || (p == PERM_NONE);
      endcase
      return deny;
   endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic [ENTRIES-1:0] ent_valid,
   input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
   input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
   input  logic [VPN_W-1:0]   key_vpn,
   input  logic [ASID_W-1:0]  key_asid,
   output logic [ENTRIES-1:0] match
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) &&
                        (ent_asid[g] == key_asid);
   end
endmodule

// File: rtl/tlb_onehot_enc.sv
module tlb_onehot_enc #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic [ENTRIES-1:0] vec,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      any = |vec;
      idx = '0;
      for (int k = 0; k < ENTRIES; k++) begin
         if (vec[k]) idx = idx | IDX_W'(k);
      end
   end
endmodule

// File: rtl/tlb_rr_pick.sv
module tlb_rr_pick #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic [ENTRIES-1:0] elig,
   input  logic [IDX_W-1:0]   start,
   output logic               found,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = 0; k < ENTRIES; k++) begin
         int j;
         j = (int'(start) + k) % ENTRIES;
         if (!found && elig[j]) begin
            found = 1'b1;
            idx   = IDX_W'(j);
         end
      end
   end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [1:0]        lk_kind,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_fault,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic [1:0]        rsp_perm,
   input  logic              rf_valid,
   input  logic [VPN_W-1:0]  rf_vpn,
   input  logic [ASID_W-1:0] rf_asid,
   input  logic [PFN_W-1:0]  rf_pfn,
   input  logic [1:0]        rf_perm,
   input  logic              rf_wired,
   output logic              rf_drop,
   input  logic              fl_valid,
   input  logic              fl_by_asid,
   input  logic [ASID_W-1:0] fl_asid
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   if (ENTRIES < 2 || ENTRIES > 1024) begin : g_bad_entries
      $error("asid_tlb: ENTRIES must lie in 2..1024");
   end
   if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("asid_tlb: field widths must be positive");
   end

   // table state
   logic [ENTRIES-1:0] ent_valid;
   logic [ENTRIES-1:0] ent_wired;
   logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
   logic [ASID_W-1:0]  ent_asid [ENTRIES];
   logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
   logic [1:0]         ent_perm [ENTRIES];
   logic [IDX_W-1:0]   rr_ptr;

   // lookup path
   logic [ENTRIES-1:0] lk_match;
   logic               lk_any;
   logic [IDX_W-1:0]   lk_idx;
   logic               lk_deny;

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
      .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
      .key_vpn(lk_vpn), .key_asid(lk_asid), .match(lk_match)
   );

   tlb_onehot_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_enc (
      .vec(lk_match), .any(lk_any), .idx(lk_idx)
   );

   assign lk_deny = access_denied(perm_e'(ent_perm[lk_idx]), acc_e'(lk_kind));

   // refill path
   logic [ENTRIES-1:0] rf_match;
   logic               rf_hit_any;
   logic [IDX_W-1:0]   rf_hit_idx;
   logic [ENTRIES-1:0] rr_elig;
   logic               rr_found;
   logic [IDX_W-1:0]   rr_idx;
   logic               wr_en;
   logic [IDX_W-1:0]   wr_idx;
   logic               drop_now;

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_cam (
      .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
      .key_vpn(rf_vpn), .key_asid(rf_asid), .match(rf_match)
   );

   tlb_onehot_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rf_enc (
      .vec(rf_match), .any(rf_hit_any), .idx(rf_hit_idx)
   );

   assign rr_elig = ~(ent_valid & ent_wired);

   tlb_rr_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
      .elig(rr_elig), .start(rr_ptr), .found(rr_found), .idx(rr_idx)
   );

   assign wr_en    = rf_valid && (rf_hit_any || rr_found);
   assign wr_idx   = rf_hit_any ? rf_hit_idx : rr_idx;
   assign drop_now = rf_valid && !rf_hit_any && !rr_found;

   // flush selection
   logic [ENTRIES-1:0] fl_kill;
   for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
      assign fl_kill[g] = fl_valid && ent_valid[g] && !ent_wired[g] &&
                          (!fl_by_asid || (ent_asid[g] == fl_asid));
   end

   // control state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid <= '0;
         ent_wired <= '0;
         rr_ptr    <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
               ent_valid[i] <= 1'b1;
               ent_wired[i] <= rf_wired;
            end else if (fl_kill[i]) begin
               ent_valid[i] <= 1'b0;
               ent_wired[i] <= 1'b0;
            end
         end
         if (wr_en && !rf_hit_any) begin
            rr_ptr <= (rr_idx == LAST_IDX) ? '0 : rr_idx + 1'b1;
         end
      end
   end

   // payload, no reset needed
   always_ff @(posedge clk) begin
      if (wr_en) begin
         ent_vpn[wr_idx]  <= rf_vpn;
         ent_asid[wr_idx] <= rf_asid;
         ent_pfn[wr_idx]  <= rf_pfn;
         ent_perm[wr_idx] <= rf_perm;
      end
   end

   // registered response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_pfn   <= '0;
         rsp_perm  <= '0;
         rf_drop   <= 1'b0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && lk_any && !lk_deny;
         rsp_miss  <= lk_valid && !lk_any;
         rsp_fault <= lk_valid && lk_any && lk_deny;
         rsp_pfn   <= (lk_valid && lk_any) ? ent_pfn[lk_idx] : '0;
         rsp_perm  <= (lk_valid && lk_any) ? ent_perm[lk_idx] : '0;
         rf_drop   <= drop_now;
      end
   end

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
   parameter int ENTRIES = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic               rsp_miss,
   input logic               rsp_fault,
   input logic               rf_valid,
   input logic               rf_drop,
   input logic               fl_valid,
   input logic               fl_by_asid,
   input logic [ENTRIES-1:0] ent_valid,
   input logic [ENTRIES-1:0] ent_wired
);
   logic all_pinned;
   assign all_pinned = &(ent_valid & ent_wired);

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid); // R11
   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid); // R11
   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1)); // R11
   AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> ({rsp_hit, rsp_miss, rsp_fault} == 3'b000)); // R11
   AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && !all_pinned) |=> !rf_drop); // R6
   AST_FLUSH_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_valid && !fl_by_asid && !rf_valid) |=> ((ent_valid & ~ent_wired) == '0)); // R8

   for (genvar g = 0; g < ENTRIES; g++) begin : g_pin
      AST_PIN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (ent_valid[g] && ent_wired[g]) |=> ent_valid[g]); // R7
   end
endmodule

bind asid_tlb tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
   .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
   .rf_valid(rf_valid), .rf_drop(rf_drop), .fl_valid(fl_valid),
   .fl_by_asid(fl_by_asid), .ent_valid(ent_valid), .ent_wired(ent_wired)
);

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;
   localparam int N  = 8;
   localparam int VW = 12;
   localparam int PW = 10;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          lk_valid = 0, rf_valid = 0, rf_wired = 0, fl_valid = 0, fl_by_asid = 0;
   logic [VW-1:0] lk_vpn = '0, rf_vpn = '0;
   logic [AW-1:0] lk_asid = '0, rf_asid = '0, fl_asid = '0;
   logic [1:0]    lk_kind = '0, rf_perm = '0, rsp_perm;
   logic [PW-1:0] rf_pfn = '0, rsp_pfn;
   logic          rsp_valid, rsp_hit, rsp_miss, rsp_fault, rf_drop;

   asid_tlb #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) dut (.*);

   // stimulus for the next tick
   logic d_lk, d_rf, d_rfw, d_fl, d_flm;
   logic [VW-1:0] d_lvpn, d_rvpn;
   logic [AW-1:0] d_lasid, d_rasid, d_fasid;
   logic [1:0] d_kind, d_rperm;
   logic [PW-1:0] d_rpfn;

   // reference model
   bit      m_valid [N];
   bit      m_wired [N];
   int      m_vpn [N], m_asid [N], m_pfn [N], m_perm [N];
   int      m_ptr;
   bit      e_valid, e_hit, e_miss, e_fault, e_drop;
   int      e_pfn, e_perm;
   string   cur_tag, next_tag;
   int      checks = 0, errors = 0;
   bit      done = 0;

   function automatic bit denied(int perm, int kind);
      if (perm == 3) return 1;
      if (kind == 1) return perm != 1;
      if (kind == 2) return 0;
      return perm == 2;
   endfunction

   task automatic clear_drive();
      d_lk = 0; d_rf = 0; d_rfw = 0; d_fl = 0; d_flm = 0;
      d_lvpn = '0; d_rvpn = '0; d_lasid = '0; d_rasid = '0; d_fasid = '0;
      d_kind = '0; d_rperm = '0; d_rpfn = '0;
   endtask

   task automatic tick(string tag);
      int hit_i, tgt;
      bit drop;
      @(negedge clk);
      checks++;
      if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rf_drop} !== {e_valid, e_hit, e_miss, e_fault, e_drop}
          || int'(rsp_pfn) != e_pfn || int'(rsp_perm) != e_perm) begin
         errors++;
         $display("FAIL %s: got v%0b h%0b m%0b f%0b d%0b pfn %0h perm %0d, expected v%0b h%0b m%0b f%0b d%0b pfn %0h perm %0d",
                  cur_tag, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rf_drop, rsp_pfn, rsp_perm,
                  e_valid, e_hit, e_miss, e_fault, e_drop, e_pfn, e_perm);
      end
      cur_tag = tag;
      lk_valid = d_lk; lk_vpn = d_lvpn; lk_asid = d_lasid; lk_kind = d_kind;
      rf_valid = d_rf; rf_vpn = d_rvpn; rf_asid = d_rasid; rf_pfn = d_rpfn;
      rf_perm = d_rperm; rf_wired = d_rfw;
      fl_valid = d_fl; fl_by_asid = d_flm; fl_asid = d_fasid;
      // lookup on pre-state
      e_valid = d_lk; e_hit = 0; e_miss = 0; e_fault = 0; e_pfn = 0; e_perm = 0;
      if (d_lk) begin
         hit_i = -1;
         for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == int'(d_lvpn) && m_asid[i] == int'(d_lasid)) hit_i = i;
         if (hit_i < 0) e_miss = 1;
         else begin
            e_pfn = m_pfn[hit_i]; e_perm = m_perm[hit_i];
            if (denied(m_perm[hit_i], int'(d_kind))) e_fault = 1; else e_hit = 1;
         end
      end
      // refill target on pre-state
      tgt = -1; drop = 0; hit_i = -1;
      if (d_rf) begin
         for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == int'(d_rvpn) && m_asid[i] == int'(d_rasid)) hit_i = i;
         if (hit_i >= 0) tgt = hit_i;
         else begin
            for (int k = 0; k < N; k++) begin
               int j = (m_ptr + k) % N;
               if (tgt < 0 && !(m_valid[j] && m_wired[j])) tgt = j;
            end
            if (tgt < 0) drop = 1;
            else m_ptr = (tgt + 1) % N;
         end
      end
      e_drop = drop;
      if (d_fl)
         for (int i = 0; i < N; i++)
            if (m_valid[i] && !m_wired[i] && (!d_flm || m_asid[i] == int'(d_fasid))) begin
               m_valid[i] = 0; m_wired[i] = 0;
            end
      if (tgt >= 0) begin
         m_valid[tgt] = 1; m_wired[tgt] = d_rfw; m_vpn[tgt] = int'(d_rvpn);
         m_asid[tgt] = int'(d_rasid); m_pfn[tgt] = int'(d_rpfn); m_perm[tgt] = int'(d_rperm);
      end
      clear_drive();
   endtask

   task automatic look(int vpn, int asid, int kind, string tag);
      d_lk = 1; d_lvpn = VW'(vpn); d_lasid = AW'(asid); d_kind = 2'(kind);
      tick(tag);
   endtask

   task automatic set_fill(int vpn, int asid, int pfn, int perm, bit wired);
      d_rf = 1; d_rvpn = VW'(vpn); d_rasid = AW'(asid); d_rpfn = PW'(pfn);
      d_rperm = 2'(perm); d_rfw = wired;
   endtask

   task automatic fill(int vpn, int asid, int pfn, int perm, bit wired, string tag);
      set_fill(vpn, asid, pfn, perm, wired);
      tick(tag);
   endtask

   task automatic flush(bit by_asid, int asid, string tag);
      d_fl = 1; d_flm = by_asid; d_fasid = AW'(asid);
      tick(tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R11: watchdog expired, got hang, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 0; m_wired[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
      end
      m_ptr = 0; e_valid = 0; e_hit = 0; e_miss = 0; e_fault = 0; e_drop = 0; e_pfn = 0; e_perm = 0;
      cur_tag = "R11 reset"; next_tag = "";
      clear_drive();
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      tick("R11 idle after reset");
      look('h10, 1, 0, "R2 empty miss");
      tick("R2 miss flags");
      // install and hit
      fill('h10, 1, 'h3A, 1, 0, "R3 refill");
      look('h10, 1, 0, "R1 read hit");
      look('h10, 1, 1, "R4 write on read-write");
      look('h10, 2, 0, "R2 other space misses");
      look('h11, 1, 0, "R2 other page misses");
      // permission matrix
      fill('h20, 1, 'h21, 0, 0, "R3 refill read-only");
      fill('h21, 1, 'h22, 2, 0, "R3 refill execute-only");
      fill('h22, 1, 'h23, 3, 0, "R3 refill no-access");
      look('h20, 1, 1, "R4 write to read-only faults");
      look('h20, 1, 2, "R4 execute on read-only");
      look('h21, 1, 0, "R4 read of execute-only faults");
      look('h21, 1, 2, "R4 execute on execute-only");
      look('h21, 1, 3, "R4 kind 3 acts as read");
      look('h22, 1, 2, "R4 no-access faults");
      // overwrite in place
      fill('h10, 1, 'h155, 0, 0, "R10 overwrite");
      look('h10, 1, 0, "R10 new frame");
      look('h10, 1, 1, "R10 new permission");
      // fill past capacity for round-robin eviction
      for (int k = 0; k < 10; k++) fill('h100 + k, 1, 'h40 + k, 1, 0, "R5 fill");
      for (int k = 0; k < 10; k++) look('h100 + k, 1, 0, "R5 eviction order");
      look('h10, 1, 0, "R5 oldest evicted");
      // pinned entries survive flush and eviction
      fill('h200, 2, 'h80, 1, 1, "R7 pinned refill");
      fill('h201, 2, 'h81, 0, 1, "R7 pinned refill");
      for (int k = 0; k < 9; k++) fill('h300 + k, 2, 'h90 + k, 1, 0, "R7 churn");
      look('h200, 2, 0, "R7 pinned kept");
      look('h201, 2, 0, "R7 pinned kept");
      flush(0, 0, "R8 flush all");
      for (int k = 0; k < 9; k++) look('h300 + k, 2, 0, "R8 unpinned gone");
      look('h200, 2, 0, "R8 pinned survives");
      // flush by identifier
      fill('h400, 3, 'h1, 1, 0, "R9 fill space 3");
      fill('h401, 3, 'h2, 1, 0, "R9 fill space 3");
      fill('h400, 4, 'h3, 1, 0, "R9 fill space 4");
      fill('h402, 3, 'h4, 1, 1, "R9 pinned space 3");
      flush(1, 3, "R9 flush space 3");
      look('h400, 3, 0, "R9 space 3 gone");
      look('h401, 3, 0, "R9 space 3 gone");
      look('h400, 4, 0, "R9 space 4 kept");
      look('h402, 3, 0, "R9 pinned kept");
      // same-cycle lookup and refill
      d_lk = 1; d_lvpn = VW'('h500); d_lasid = AW'(5); d_kind = 2'd0;
      set_fill('h500, 5, 'h77, 1, 0);
      tick("R12 lookup sees old table");
      look('h500, 5, 0, "R12 refill visible next");
      // same-cycle flush and refill
      d_fl = 1; d_flm = 0;
      set_fill('h501, 5, 'h78, 0, 0);
      tick("R12 flush with refill");
      look('h501, 5, 0, "R12 refill survives flush");
      look('h500, 5, 0, "R12 flush took old entry");
      // pin every entry, then drop
      for (int k = 0; k < 6; k++) fill('h600 + k, 6, 'hA0 + k, 1, 1, "R6 pin all");
      fill('h700, 6, 'hBB, 1, 0, "R6 refill dropped");
      tick("R6 drop pulse");
      tick("R6 drop lasts one cycle");
      look('h700, 6, 0, "R6 dropped entry absent");
      fill('h600, 6, 'hCC, 0, 1, "R10 overwrite when full");
      tick("R10 no drop on overwrite");
      look('h600, 6, 1, "R10 overwritten pinned entry");
      flush(0, 0, "R7 flush with all pinned");
      look('h601, 6, 0, "R7 still pinned");
      tick("R11 final");
      tick("R11 final");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule